// File: doc/BRIEF.md
# System Sleep State Sequencer

This block steps a system between its working state and a set of low-power states. Software selects a sleep type through a small register bus and sets a start bit in the same control register. The block then drives level control signals one at a time, in an order fixed for each kind of state: processor stop-grant, processor clock stop, memory self-refresh, system clock standby, CPU reset, CPU power and main power enables, and memory isolation. When the last step is done, a wake-status flag is raised.

Each sleep-type code is looked up in a small programmable table that names the kind of state it selects. There are four kinds: light, memory-keep, suspend and off. Consecutive control changes are spaced by a programmable settle count. A wake event that the mask allows, or the power button, undoes the steps taken so far in reverse order. This holds both when the system is fully asleep and when entry is still in progress. From the off state, only the power button brings the system back. Software must clear the wake-status flag before it can start another sleep.

Top module: `slp_seq_ctrl`

## Requirements
- R1: After reset, cpu_pwr_en and main_pwr_en are 1 and every other control output is 0. Wake status reads 0, every table entry reads 0, the settle register reads 3 and the control register reads 0.
- R2: The control register is at offset 0. Bits [2:0] hold the sleep type and bit 3 is the start bit. A write with bit 3 set uses the type carried by that same write. Bit 3 always reads 0.
- R3: The table entry for code c is at offset 8+c, with the kind in bits [2:0]: 1 light, 2 memory-keep, 3 suspend, 4 off, any other value none. A start write whose code maps to none changes nothing.
- R4: Light entry asserts, in this order, stop_grant_req, cpu_clk_stop, mem_selfref_req and sys_clk_standby. Wake undoes them in the reverse order.
- R5: Memory-keep entry performs, in this order: assert sys_clk_standby, assert mem_selfref_req, assert cpu_reset, drop cpu_pwr_en. Wake restores CPU power while reset is still held, then releases reset, self-refresh and standby in that order.
- R6: Suspend entry performs, in this order: assert mem_selfref_req, assert mem_isolate, drop main_pwr_en. Wake reverses these steps.
- R7: Off entry drops main_pwr_en. Only pwr_btn leaves the off state; enabled wake events have no effect there.
- R8: Within a sequence, consecutive output changes are exactly settle+1 cycles apart. The settle value is the register at offset 2.
- R9: A wake is pwr_btn or any bit of wake_evt AND wake_en. An event whose mask bit is 0 has no effect.
- R10: A wake during entry aborts it. Only the steps already taken are undone, in reverse order, and wake status stays 0.
- R11: Wake status (offset 1, bit 0) is set when entry completes and is cleared by writing 1 to it. While it is set, a start write is ignored.
- R12: From an accepted start write until the block is back in the working state, all register writes are ignored. Reads still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on the next cycle |
| bus_addr | input | TYPE_W+1 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| wake_evt | input | NWAKE | Wake event inputs |
| wake_en | input | NWAKE | Wake event enable mask |
| pwr_btn | input | 1 | Power button, always a wake source |
| stop_grant_req | output | 1 | Processor stop-grant request |
| cpu_clk_stop | output | 1 | Processor clock stop |
| mem_selfref_req | output | 1 | Memory self-refresh request |
| sys_clk_standby | output | 1 | System clock generator standby |
| cpu_reset | output | 1 | CPU held in reset |
| cpu_pwr_en | output | 1 | CPU and cache power enable |
| main_pwr_en | output | 1 | Main power enable |
| mem_isolate | output | 1 | Isolation of the memory-holding devices |

## Verification
If the step index or the latched kind goes wrong, the wrong output moves. That shows as a changed control vector within settle+1 cycles of the previous step, or as a reverse pass that restores a different set of signals. A faulty settle counter shows as a gap between outputs that differs from settle+1 on the very next step. A stuck wake-status flag or busy gate shows on the next start attempt or readback: either a sequence that never begins, or a register value that changed while it should have been locked.

// File: rtl/slp_seq_pkg.sv
package slp_seq_pkg;

  typedef enum logic [2:0] {
    KIND_NONE    = 3'd0,
    KIND_LIGHT   = 3'd1,
    KIND_MEMKEEP = 3'd2,
    KIND_SUSPEND = 3'd3,
    KIND_OFF     = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_ENTER,
    ENG_ASLEEP,
    ENG_EXIT
  } eng_e;

  // action bit positions; a set bit means the low-power action is applied
  localparam int NACT      = 8;
  localparam int ACT_W     = $clog2(NACT);
  localparam int A_STOPGNT = 0;
  localparam int A_CPUCLK  = 1;
  localparam int A_SELFREF = 2;
  localparam int A_SYSSTBY = 3;
  localparam int A_CPURST  = 4;
  localparam int A_CPUOFF  = 5;
  localparam int A_MEMISO  = 6;
  localparam int A_MAINOFF = 7;

  localparam int MAX_STEPS = 4;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);

endpackage

// File: rtl/slp_settle_timer.sv
module slp_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/slp_step_table.sv
module slp_step_table
  import slp_seq_pkg::*;
(
  input  kind_e              kind,
  input  logic [STEP_W-1:0]  idx,
  output logic [ACT_W-1:0]   act_sel,
  output logic [STEP_W-1:0]  n_steps
);

  always_comb begin
    act_sel = '0;
    n_steps = '0;
    case (kind)
      KIND_LIGHT: begin
        n_steps = STEP_W'(4);
        case (idx)
          STEP_W'(0): act_sel = ACT_W'(A_STOPGNT);
          STEP_W'(1): act_sel = ACT_W'(A_CPUCLK);
          STEP_W'(2): act_sel = ACT_W'(A_SELFREF);
          default:    act_sel = ACT_W'(A_SYSSTBY);
        endcase
      end
      KIND_MEMKEEP: begin
        n_steps = STEP_W'(4);
        case (idx)
          STEP_W'(0): act_sel = ACT_W'(A_SYSSTBY);
          STEP_W'(1): act_sel = ACT_W'(A_SELFREF);
          STEP_W'(2): act_sel = ACT_W'(A_CPURST);
          default:    act_sel = ACT_W'(A_CPUOFF);
        endcase
      end
      KIND_SUSPEND: begin
        n_steps = STEP_W'(3);
        case (idx)
          STEP_W'(0): act_sel = ACT_W'(A_SELFREF);
          STEP_W'(1): act_sel = ACT_W'(A_MEMISO);
          default:    act_sel = ACT_W'(A_MAINOFF);
        endcase
      end
      KIND_OFF: begin
        n_steps = STEP_W'(1);
        act_sel = ACT_W'(A_MAINOFF);
      end
      default: begin
        n_steps = '0;
        act_sel = '0;
      end
    endcase
  end

endmodule

// File: rtl/slp_regs.sv
module slp_regs
  import slp_seq_pkg::*;
#(
  parameter int TYPE_W     = 3,
  parameter int DATA_W     = 8,
  parameter int SETTLE_RST = 3,
  localparam int ADDR_W    = TYPE_W + 1,
  localparam int NTYPE     = 1 << TYPE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              sleep_done,
  output logic              start,
  output kind_e             start_kind,
  output logic [DATA_W-1:0] settle_q
);

  localparam logic [ADDR_W-1:0] REG_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] REG_STAT   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] REG_SETTLE = ADDR_W'(2);

  logic [TYPE_W-1:0] type_q;
  logic              wake_sts;
  logic [2:0]        map_mem [NTYPE];

  logic              busy_eff;
  logic              wr_ok;
  logic              is_map;
  logic [TYPE_W-1:0] new_type;
  kind_e             new_kind;

  function automatic kind_e decode_kind(input logic [2:0] v);
    case (v)
      3'd1:    decode_kind = KIND_LIGHT;
      3'd2:    decode_kind = KIND_MEMKEEP;
      3'd3:    decode_kind = KIND_SUSPEND;
      3'd4:    decode_kind = KIND_OFF;
      default: decode_kind = KIND_NONE;
    endcase
  endfunction

  assign busy_eff = busy | start;
  assign wr_ok    = bus_wr & ~busy_eff;
  assign is_map   = bus_addr[TYPE_W];
  assign new_type = bus_wdata[TYPE_W-1:0];
  assign new_kind = decode_kind(map_mem[new_type]);

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q     <= '0;
      settle_q   <= DATA_W'(SETTLE_RST);
      wake_sts   <= 1'b0;
      start      <= 1'b0;
      start_kind <= KIND_NONE;
      for (int i = 0; i < NTYPE; i++) map_mem[i] <= '0;
    end else begin
      start <= 1'b0;
      if (wr_ok && is_map) map_mem[bus_addr[TYPE_W-1:0]] <= bus_wdata[2:0];
      if (wr_ok && bus_addr == REG_SETTLE) settle_q <= bus_wdata;
      if (wr_ok && bus_addr == REG_CTRL) begin
        type_q <= new_type;
        if (bus_wdata[TYPE_W] && !wake_sts && new_kind != KIND_NONE) begin
          start      <= 1'b1;
          start_kind <= new_kind;
        end
      end
      if (sleep_done) begin
        wake_sts <= 1'b1;
      end else if (wr_ok && bus_addr == REG_STAT && bus_wdata[0]) begin
        wake_sts <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (is_map) begin
        bus_rdata <= DATA_W'(map_mem[bus_addr[TYPE_W-1:0]]);
      end else begin
        case (bus_addr)
          REG_CTRL:   bus_rdata <= DATA_W'(type_q);
          REG_STAT:   bus_rdata <= DATA_W'(wake_sts);
          REG_SETTLE: bus_rdata <= settle_q;
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_eff && bus_wr) |=> ($stable(type_q) && $stable(settle_q)));

  // R11
  wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !$past(wake_sts));

endmodule

// File: rtl/slp_engine.sv
module slp_engine
  import slp_seq_pkg::*;
#(
  parameter int NWAKE = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  kind_e            start_kind,
  input  logic [CNT_W-1:0] settle,
  input  logic [NWAKE-1:0] wake_evt,
  input  logic [NWAKE-1:0] wake_en,
  input  logic             pwr_btn,
  output logic [NACT-1:0]  act,
  output logic             sleep_done,
  output logic             busy
);

  eng_e              state;
  kind_e             kind_q;
  logic [STEP_W-1:0] stepn;
  logic [STEP_W-1:0] lut_idx;
  logic [ACT_W-1:0]  act_sel;
  logic [STEP_W-1:0] n_steps;
  logic              tmr_load;
  logic              tmr_zero;
  logic              wake_hit;

  assign wake_hit = (kind_q == KIND_OFF) ? pwr_btn
                                         : (pwr_btn | (|(wake_evt & wake_en)));
  assign lut_idx  = (state == ENG_EXIT) ? (stepn - STEP_W'(1)) : stepn;
  assign busy     = (state != ENG_IDLE);

  slp_step_table u_steps (
    .kind    (kind_q),
    .idx     (lut_idx),
    .act_sel (act_sel),
    .n_steps (n_steps)
  );

  slp_settle_timer #(.W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (settle),
    .expired  (tmr_zero)
  );

  always_comb begin
    tmr_load = 1'b0;
    case (state)
      ENG_IDLE:   tmr_load = start && (start_kind != KIND_NONE);
      ENG_ENTER:  tmr_load = wake_hit || tmr_zero;
      ENG_ASLEEP: tmr_load = wake_hit;
      ENG_EXIT:   tmr_load = tmr_zero;
      default:    tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ENG_IDLE;
      kind_q     <= KIND_NONE;
      stepn      <= '0;
      act        <= '0;
      sleep_done <= 1'b0;
    end else begin
      sleep_done <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (start && start_kind != KIND_NONE) begin
            kind_q <= start_kind;
            stepn  <= '0;
            state  <= ENG_ENTER;
          end
        end
        ENG_ENTER: begin
          if (wake_hit) begin
            state <= (stepn == '0) ? ENG_IDLE : ENG_EXIT;
          end else if (tmr_zero) begin
            act[act_sel] <= 1'b1;
            stepn        <= stepn + STEP_W'(1);
            if ((stepn + STEP_W'(1)) == n_steps) begin
              state      <= ENG_ASLEEP;
              sleep_done <= 1'b1;
            end
          end
        end
        ENG_ASLEEP: begin
          if (wake_hit) state <= ENG_EXIT;
        end
        ENG_EXIT: begin
          if (tmr_zero) begin
            act[act_sel] <= 1'b0;
            stepn        <= stepn - STEP_W'(1);
            if (stepn == STEP_W'(1)) state <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(act ^ $past(act)) <= 1);

  // R8
  settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (act != $past(act)) |-> $past(tmr_zero));

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE) |-> (act == '0));

  // R10
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    stepn <= n_steps);

endmodule

// File: rtl/slp_seq_ctrl.sv
module slp_seq_ctrl
  import slp_seq_pkg::*;
#(
  parameter int NWAKE      = 4,
  parameter int TYPE_W     = 3,
  parameter int DATA_W     = 8,
  parameter int SETTLE_RST = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [TYPE_W:0]   bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NWAKE-1:0]  wake_evt,
  input  logic [NWAKE-1:0]  wake_en,
  input  logic              pwr_btn,
  output logic              stop_grant_req,
  output logic              cpu_clk_stop,
  output logic              mem_selfref_req,
  output logic              sys_clk_standby,
  output logic              cpu_reset,
  output logic              cpu_pwr_en,
  output logic              main_pwr_en,
  output logic              mem_isolate
);

  logic              start;
  kind_e             start_kind;
  logic [DATA_W-1:0] settle_q;
  logic [NACT-1:0]   act;
  logic              sleep_done;
  logic              busy;

  slp_regs #(
    .TYPE_W     (TYPE_W),
    .DATA_W     (DATA_W),
    .SETTLE_RST (SETTLE_RST)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .sleep_done (sleep_done),
    .start      (start),
    .start_kind (start_kind),
    .settle_q   (settle_q)
  );

  slp_engine #(
    .NWAKE (NWAKE),
    .CNT_W (DATA_W)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_kind (start_kind),
    .settle     (settle_q),
    .wake_evt   (wake_evt),
    .wake_en    (wake_en),
    .pwr_btn    (pwr_btn),
    .act        (act),
    .sleep_done (sleep_done),
    .busy       (busy)
  );

  assign stop_grant_req  = act[A_STOPGNT];
  assign cpu_clk_stop    = act[A_CPUCLK];
  assign mem_selfref_req = act[A_SELFREF];
  assign sys_clk_standby = act[A_SYSSTBY];
  assign cpu_reset       = act[A_CPURST];
  assign cpu_pwr_en      = ~act[A_CPUOFF];
  assign mem_isolate     = act[A_MEMISO];
  assign main_pwr_en     = ~act[A_MAINOFF];

endmodule

// File: tb/slp_seq_ctrl_tb.sv
module slp_seq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] wake_evt = '0;
  logic [3:0] wake_en = '0;
  logic       pwr_btn = 1'b0;
  logic stop_grant_req, cpu_clk_stop, mem_selfref_req, sys_clk_standby;
  logic cpu_reset, cpu_pwr_en, main_pwr_en, mem_isolate;

  always #5 clk = ~clk;

  slp_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_evt(wake_evt), .wake_en(wake_en), .pwr_btn(pwr_btn),
    .stop_grant_req(stop_grant_req), .cpu_clk_stop(cpu_clk_stop),
    .mem_selfref_req(mem_selfref_req), .sys_clk_standby(sys_clk_standby),
    .cpu_reset(cpu_reset), .cpu_pwr_en(cpu_pwr_en),
    .main_pwr_en(main_pwr_en), .mem_isolate(mem_isolate)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int cur_settle = 3;
  bit seq_first = 1'b1;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [7:0] vec();
    return {mem_isolate, main_pwr_en, cpu_pwr_en, cpu_reset,
            sys_clk_standby, mem_selfref_req, cpu_clk_stop, stop_grant_req};
  endfunction

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic push(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expected vector per output change
  logic [7:0] last_v = 8'h60;
  int         last_cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst && vec() != last_v) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4/R9 unexpected change", int'(vec()), int'(last_v));
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(vec() == e, t, int'(vec()), int'(e));
        if (!seq_first)
          check((cyc - last_cyc) == cur_settle + 1, "R8 gap", cyc - last_cyc, cur_settle + 1);
        seq_first = 1'b0;
      end
      last_v   = vec();
      last_cyc = cyc;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic start_seq(input logic [2:0] code);
    seq_first = 1'b1;
    wr(4'd0, {4'b0001, 1'b0, code} | 8'h08);
  endtask

  task automatic pulse_wake(input logic [3:0] evt, input bit btn);
    @(negedge clk);
    seq_first = 1'b1;
    wake_evt = evt; pwr_btn = btn;
    @(negedge clk);
    wake_evt = '0; pwr_btn = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(vec() == 8'h60, "R1 outputs", int'(vec()), 'h60);
    rd(4'd1, d); check(d == 8'h00, "R1 wake status", int'(d), 0);
    rd(4'd2, d); check(d == 8'h03, "R1 settle", int'(d), 3);
    rd(4'd9, d); check(d == 8'h00, "R1 table entry", int'(d), 0);
    rd(4'd0, d); check(d == 8'h00, "R1 control", int'(d), 0);

    // R3 start with unmapped code is a no-op
    start_seq(3'd1);
    repeat (12) @(negedge clk);
    check(vec() == 8'h60, "R3 unmapped start", int'(vec()), 'h60);
    rd(4'd1, d); check(d == 8'h00, "R3 no wake status", int'(d), 0);

    // program table and settle
    wr(4'd9, 8'd1); wr(4'd10, 8'd2); wr(4'd11, 8'd3); wr(4'd13, 8'd4);
    wr(4'd2, 8'd2); cur_settle = 2;
    rd(4'd10, d); check(d == 8'h02, "R3 table readback", int'(d), 2);

    // R2 + R4: preload type 5, then one write carrying type 1 and start
    wr(4'd0, 8'h05);
    push(8'h61, "R4 step1"); push(8'h63, "R4 step2");
    push(8'h67, "R4 step3"); push(8'h6F, "R4 step4");
    start_seq(3'd1);
    drain();
    rd(4'd1, d); check(d == 8'h01, "R11 wake status set", int'(d), 1);
    rd(4'd0, d); check(d == 8'h01, "R2 type kept, start reads 0", int'(d), 1);

    // R9 masked event ignored
    wake_en = 4'b0000;
    pulse_wake(4'b0010, 1'b0);
    repeat (10) @(negedge clk);
    check(vec() == 8'h6F, "R9 masked wake", int'(vec()), 'h6F);

    // R4 reverse on enabled wake
    wake_en = 4'b0010;
    push(8'h67, "R4 exit1"); push(8'h63, "R4 exit2");
    push(8'h61, "R4 exit3"); push(8'h60, "R4 exit4");
    pulse_wake(4'b0010, 1'b0);
    drain();

    // R11 start ignored while wake status set
    start_seq(3'd3);
    repeat (15) @(negedge clk);
    check(vec() == 8'h60, "R11 start blocked", int'(vec()), 'h60);
    wr(4'd1, 8'h01);
    rd(4'd1, d); check(d == 8'h00, "R11 cleared", int'(d), 0);

    // R5 memory-keep
    push(8'h68, "R5 step1"); push(8'h6C, "R5 step2");
    push(8'h7C, "R5 step3"); push(8'h5C, "R5 step4");
    start_seq(3'd2);
    drain();
    // R12 write ignored while asleep
    wr(4'd2, 8'd9);
    rd(4'd2, d); check(d == 8'h02, "R12 settle locked", int'(d), 2);
    push(8'h7C, "R5 exit1"); push(8'h6C, "R5 exit2");
    push(8'h68, "R5 exit3"); push(8'h60, "R5 exit4");
    pulse_wake(4'b0000, 1'b1);
    drain();
    wr(4'd1, 8'h01);

    // R6 suspend, with a write during entry (R12)
    push(8'h64, "R6 step1"); push(8'hE4, "R6 step2"); push(8'hA4, "R6 step3");
    start_seq(3'd3);
    wr(4'd0, 8'h01);
    drain();
    rd(4'd0, d); check(d == 8'h03, "R12 control locked", int'(d), 3);
    push(8'hE4, "R6 exit1"); push(8'h64, "R6 exit2"); push(8'h60, "R6 exit3");
    pulse_wake(4'b0010, 1'b0);
    drain();
    wr(4'd1, 8'h01);

    // R7 off: enabled events ignored, button exits
    push(8'h20, "R7 step1");
    start_seq(3'd5);
    drain();
    pulse_wake(4'b0010, 1'b0);
    repeat (10) @(negedge clk);
    check(vec() == 8'h20, "R7 event ignored in off", int'(vec()), 'h20);
    push(8'h60, "R7 button exit");
    pulse_wake(4'b0000, 1'b1);
    drain();
    wr(4'd1, 8'h01);

    // R10 abort partway through suspend entry
    wr(4'd2, 8'd6); cur_settle = 6;
    push(8'h64, "R10 step1"); push(8'h60, "R10 undo");
    start_seq(3'd3);
    while (vec() != 8'h64) @(negedge clk);
    @(negedge clk);
    pulse_wake(4'b0010, 1'b0);
    drain();
    repeat (20) @(negedge clk);
    check(vec() == 8'h60, "R10 back to working", int'(vec()), 'h60);
    rd(4'd1, d); check(d == 8'h00, "R10 no wake status", int'(d), 0);

    // R3 code mapped to none
    start_seq(3'd6);
    repeat (15) @(negedge clk);
    check(vec() == 8'h60, "R3 code 6 no-op", int'(vec()), 'h60);

    check(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);
    finish_run();
  end

endmodule